// File: doc/BRIEF.md
# PIO Strobe Timer with Watchdog

This block times one programmed-I/O read or write strobe on a parallel disk channel. A host-side 32-bit control register sets three phase lengths: address setup, strobe active and recovery. A start pulse launches one access, and a done pulse reports its end. While the strobe is active, the block can hold the access open for as long as the device keeps its ready line low.

A 256-clock watchdog guards that wait. When the watchdog expires, it sets a sticky timeout flag, which can raise an interrupt, and ends the wait. The access then finishes normally. Ready monitoring stays off until software clears the flag by writing one to it. Two more register bits drive the channel reset output and the bus tri-state output directly.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset reg_rdata reads 0x6515_0100. The fields are: setup count [31:28], active count [27:22], recovery count [21:16], interrupt enable [14], watchdog enable [13], timeout flag [12], monitor enable [9], tri-state [3] and channel reset [2]. Bit 8 always reads one. Bits 15, 11:10, 7:4 and 1:0 always read zero, and writes to any of these bits have no effect.
- R2: A phase programmed with count N lasts N+1 clocks. With start sampled on clock edge 0, the strobe is first seen after edge S+1 and stays high A+1 clocks (S, A and R are the setup, active and recovery counts). is_write=0 uses rd_stb, is_write=1 uses wr_stb, and the other strobe stays low.
- R3: done is high for exactly one clock, after edge S+A+R+3. A start that arrives while an access is in progress is ignored.
- R4: With bit 9 set, the access stays in its active phase while ready is low, and it ends one clock after ready is sampled high. With bit 9 clear, ready has no effect.
- R5: With bits 13 and 9 set, the 256th consecutive clock of low ready during the active phase sets bit 12. The strobe then ends on the next clock, so it is high for 257 clocks.
- R6: While bit 12 is set, ready is not monitored. Writing one to bit 12 clears it, and monitoring resumes on later accesses. Writing zero to bit 12 leaves it unchanged.
- R7: irq is high exactly when bits 12 and 14 are both set.
- R8: chan_rst follows bit 2 and bus_hiz follows bit 3.
- R9: A write of the phase counts or of bit 9 during an access takes effect only from the next access.
- R10: If the watchdog expires on the same clock as a write of one to bit 12, the flag ends up set.
- R11: The watchdog count restarts whenever ready is high or the access ends. Two accesses with 199 and 149 low-ready clocks therefore do not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| start | input | 1 | Launch one access |
| is_write | input | 1 | Access direction, 1 = write |
| ready | input | 1 | Device ready line, high = ready |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock end-of-access pulse |
| irq | output | 1 | Watchdog interrupt |
| chan_rst | output | 1 | Channel reset output |
| bus_hiz | output | 1 | Channel bus tri-state output |

## Verification
The watchdog setting the timeout flag and software clearing that flag can fall in the same clock. The bench holds ready low through an access and counts strobe clocks. It issues the write-one-to-clear so that the write is sampled on exactly the edge that carries the 256th low-ready clock. The collision is judged correct when the flag reads set afterwards, irq is high, and the strobe lasted 257 clocks.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;
  localparam int SETUP_W = 4;
  localparam int ACT_W   = 6;
  localparam int REC_W   = 6;
  localparam int CNT_W   = (ACT_W > REC_W) ? ((ACT_W > SETUP_W) ? ACT_W : SETUP_W)
                                           : ((REC_W > SETUP_W) ? REC_W : SETUP_W);
  localparam int B_IE   = 14;
  localparam int B_WE   = 13;
  localparam int B_FLAG = 12;
  localparam int B_MON  = 9;
  localparam int B_HIZ  = 3;
  localparam int B_CRST = 2;
  localparam logic [SETUP_W-1:0] RST_SETUP = 4'd6;
  localparam logic [ACT_W-1:0]   RST_ACT   = 6'd20;
  localparam logic [REC_W-1:0]   RST_REC   = 6'd21;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACTIVE, PH_RECOV} phase_t;

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [ACT_W-1:0]   act;
    logic [REC_W-1:0]   rec;
    logic               ie;
    logic               we;
    logic               mon;
    logic               hiz;
    logic               crst;
  } cfg_t;
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= '0;
    else          sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
  import pio_tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        wd_set,
  output cfg_t        cfg,
  output logic        flag,
  output logic [31:0] rdata
);
  cfg_t cfg_q, cfg_n;
  logic flag_q, flag_n;

  always_comb begin
    cfg_n  = cfg_q;
    flag_n = flag_q;
    if (wr_en) begin
      cfg_n.setup = wr_data[31:28];
      cfg_n.act   = wr_data[27:22];
      cfg_n.rec   = wr_data[21:16];
      cfg_n.ie    = wr_data[B_IE];
      cfg_n.we    = wr_data[B_WE];
      cfg_n.mon   = wr_data[B_MON];
      cfg_n.hiz   = wr_data[B_HIZ];
      cfg_n.crst  = wr_data[B_CRST];
      if (wr_data[B_FLAG]) flag_n = 1'b0;
    end
    if (wd_set) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{setup: RST_SETUP, act: RST_ACT, rec: RST_REC,
                  ie: 1'b0, we: 1'b0, mon: 1'b0, hiz: 1'b0, crst: 1'b0};
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_n;
      flag_q <= flag_n;
    end
  end

  assign cfg  = cfg_q;
  assign flag = flag_q;
  assign rdata = {cfg_q.setup, cfg_q.act, cfg_q.rec,
                  1'b0, cfg_q.ie, cfg_q.we, flag_q, 2'b00,
                  cfg_q.mon, 1'b1, 4'b0000,
                  cfg_q.hiz, cfg_q.crst, 2'b00};
endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_tmr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   is_write,
  input  cfg_t   cfg,
  input  logic   flag,
  input  logic   ready,
  output logic   rd_stb,
  output logic   wr_stb,
  output logic   done,
  output logic   busy,
  output logic   mon_wait
);
  phase_t             st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [SETUP_W-1:0] s_q;
  logic [ACT_W-1:0]   a_q;
  logic [REC_W-1:0]   r_q;
  logic               mon_q, dir_q, done_q, done_n, load;

  assign mon_wait = (st_q == PH_ACTIVE) && mon_q && !flag && !ready;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    load   = 1'b0;
    unique case (st_q)
      PH_IDLE: if (start) begin
        st_n  = PH_SETUP;
        cnt_n = '0;
        load  = 1'b1;
      end
      PH_SETUP: if (cnt_q == CNT_W'(s_q)) begin
        st_n  = PH_ACTIVE;
        cnt_n = '0;
      end else cnt_n = cnt_q + 1'b1;
      PH_ACTIVE: if (cnt_q >= CNT_W'(a_q) && !mon_wait) begin
        st_n  = PH_RECOV;
        cnt_n = '0;
      end else if (cnt_q < CNT_W'(a_q)) cnt_n = cnt_q + 1'b1;
      PH_RECOV: if (cnt_q == CNT_W'(r_q)) begin
        st_n   = PH_IDLE;
        done_n = 1'b1;
      end else cnt_n = cnt_q + 1'b1;
      default: st_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q   <= '0;
      a_q   <= '0;
      r_q   <= '0;
      mon_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (load) begin
      s_q   <= cfg.setup;
      a_q   <= cfg.act;
      r_q   <= cfg.rec;
      mon_q <= cfg.mon;
      dir_q <= is_write;
    end
  end

  assign rd_stb = (st_q == PH_ACTIVE) && !dir_q;
  assign wr_stb = (st_q == PH_ACTIVE) &&  dir_q;
  assign done   = done_q;
  assign busy   = (st_q != PH_IDLE);
endmodule

// File: rtl/pio_ready_wdog.sv
module pio_ready_wdog #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic waiting,
  output logic expire
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          run;

  assign run    = en && waiting;
  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    if (!run || expire) cnt_n = '0;
    else                cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_tmr_pkg::*;
#(
  parameter int WD_LIMIT = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        start,
  input  logic        is_write,
  input  logic        ready,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic        done,
  output logic        irq,
  output logic        chan_rst,
  output logic        bus_hiz
);
  logic rst_s_n, flag, wd_set, busy, mon_wait;
  cfg_t cfg;

  pio_rst_sync #(.STAGES(2)) u_rs (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_s_n));

  pio_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(reg_wr), .wr_data(reg_wdata),
    .wd_set(wd_set), .cfg(cfg), .flag(flag), .rdata(reg_rdata));

  pio_phase_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .start(start), .is_write(is_write),
    .cfg(cfg), .flag(flag), .ready(ready), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .done(done), .busy(busy), .mon_wait(mon_wait));

  pio_ready_wdog #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_s_n), .en(cfg.we), .waiting(mon_wait),
    .expire(wd_set));

  assign irq      = flag && cfg.ie;
  assign chan_rst = cfg.crst;
  assign bus_hiz  = cfg.hiz;
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        start,
  input logic        rd_stb,
  input logic        wr_stb,
  input logic        done,
  input logic        irq,
  input logic        busy
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R2
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_stb && !wr_stb); // R3
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy ##1 busy) |-> $past(start)); // R3
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (reg_rdata[12] && reg_rdata[14])); // R7
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[12] && !(reg_wr && reg_wdata[12])) |=> reg_rdata[12]); // R6
endmodule

bind pio_strobe_timer pio_strobe_timer_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .start(start), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .done(done), .irq(irq), .busy(busy));

// File: tb/sim_pio_strobe_timer.sv
`timescale 1ns/1ps
module sim_pio_strobe_timer;
  logic clk, rst_n, reg_wr, start, is_write, ready;
  logic [31:0] reg_wdata, reg_rdata;
  logic rd_stb, wr_stb, done, irq, chan_rst, bus_hiz;
  int tests, fails;
  logic [31:0] cur;
  int gap, width, didx, dcnt, other;

  pio_strobe_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start(start), .is_write(is_write), .ready(ready),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done), .irq(irq),
    .chan_rst(chan_rst), .bus_hiz(bus_hiz));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(int s, int a, int r, bit ie, bit we,
                                     bit mon, bit hiz, bit crst);
    logic [31:0] v;
    v = '0;
    v[31:28] = 4'(s); v[27:22] = 6'(a); v[21:16] = 6'(r);
    v[14] = ie; v[13] = we; v[9] = mon; v[3] = hiz; v[2] = crst;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic run_access(input bit wrt, input int rl, input int wr_at,
                            input logic [31:0] wdat, input int restart_at);
    int idx, w;
    logic s, o;
    @(negedge clk);
    ready = (rl > 0) ? 1'b0 : 1'b1;
    start = 1'b1; is_write = wrt;
    @(negedge clk);
    start = 1'b0;
    idx = 1; w = 0; gap = 0; didx = 0; dcnt = 0; other = 0;
    for (int k = 0; k < 3000; k++) begin
      s = wrt ? wr_stb : rd_stb;
      o = wrt ? rd_stb : wr_stb;
      if (s) begin w++; if (gap == 0) gap = idx; end
      if (o) other++;
      if (done) begin dcnt++; if (didx == 0) didx = idx; end
      reg_wr = 1'b0; start = 1'b0;
      if (s && w == rl) ready = 1'b1;
      if (s && w == wr_at) begin reg_wr = 1'b1; reg_wdata = wdat; end
      if (idx == restart_at) start = 1'b1;
      if (didx != 0 && idx >= didx + 3) break;
      @(negedge clk);
      idx++;
    end
    reg_wr = 1'b0; start = 1'b0; ready = 1'b1;
    width = w;
  endtask

  task automatic t_reset;
    chk("R1 reset value", reg_rdata, 32'h6515_0100);
    chk("R2 strobes idle", {30'd0, rd_stb, wr_stb}, 32'd0);
    chk("R3 done idle", {31'd0, done}, 32'd0);
    chk("R7 irq idle", {31'd0, irq}, 32'd0);
    chk("R8 outputs idle", {30'd0, chan_rst, bus_hiz}, 32'd0);
  endtask

  task automatic t_regmap;
    wr_reg(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R1 readback all ones", reg_rdata, 32'hFFFF_630C);
    chk("R8 chan_rst/bus_hiz set", {30'd0, chan_rst, bus_hiz}, 32'd3);
    cur = mk(2, 3, 1, 0, 0, 0, 0, 0);
    wr_reg(cur);
    @(negedge clk);
    chk("R1 readback config", reg_rdata, cur | 32'h100);
    chk("R8 chan_rst/bus_hiz clear", {30'd0, chan_rst, bus_hiz}, 32'd0);
  endtask

  task automatic t_phases;
    run_access(0, 0, -1, 0, -1);
    chk("R2 read setup gap", gap, 4);
    chk("R2 read active width", width, 4);
    chk("R2 read other strobe", other, 0);
    chk("R3 read done index", didx, 2 + 3 + 1 + 4);
    chk("R3 read done once", dcnt, 1);
    cur = mk(0, 0, 0, 0, 0, 0, 0, 0);
    wr_reg(cur);
    run_access(1, 0, -1, 0, -1);
    chk("R2 write zero-count gap", gap, 2);
    chk("R2 write zero-count width", width, 1);
    chk("R2 write other strobe", other, 0);
    chk("R3 write done index", didx, 4);
  endtask

  task automatic t_busy;
    cur = mk(2, 3, 1, 0, 0, 0, 0, 0);
    wr_reg(cur);
    run_access(0, 0, -1, 0, 5);
    chk("R3 restart ignored width", width, 4);
    chk("R3 restart ignored done count", dcnt, 1);
    chk("R3 restart ignored done index", didx, 10);
  endtask

  task automatic t_mon_off;
    run_access(0, 20, -1, 0, -1);
    chk("R4 ready ignored when monitor off", width, 4);
  endtask

  task automatic t_stretch;
    cur = mk(2, 3, 1, 0, 0, 1, 0, 0);
    wr_reg(cur);
    run_access(1, 40, -1, 0, -1);
    chk("R4 stretched width", width, 40);
    chk("R4 stretched done index", didx, 4 + 40 + 2);
  endtask

  task automatic t_restart;
    cur = mk(2, 3, 1, 0, 1, 1, 0, 0);
    wr_reg(cur);
    run_access(0, 200, -1, 0, -1);
    chk("R11 first wait width", width, 200);
    run_access(0, 150, -1, 0, -1);
    chk("R11 second wait width", width, 150);
    chk("R11 no timeout across accesses", reg_rdata[12], 1'b0);
  endtask

  task automatic t_wdog;
    run_access(0, 1000, -1, 0, -1);
    chk("R5 timeout width", width, 257);
    chk("R5 flag set", reg_rdata[12], 1'b1);
    chk("R7 irq masked", irq, 1'b0);
    cur = mk(2, 3, 1, 1, 1, 1, 0, 0);
    wr_reg(cur);
    @(negedge clk);
    chk("R6 zero write keeps flag", reg_rdata[12], 1'b1);
    chk("R7 irq raised", irq, 1'b1);
  endtask

  task automatic t_suspend;
    run_access(0, 50, -1, 0, -1);
    chk("R6 monitoring suspended", width, 4);
    wr_reg(cur | 32'h1000);
    @(negedge clk);
    chk("R6 flag cleared", reg_rdata[12], 1'b0);
    chk("R7 irq cleared", irq, 1'b0);
    run_access(0, 30, -1, 0, -1);
    chk("R6 monitoring resumed", width, 30);
  endtask

  task automatic t_midwrite;
    logic [31:0] nxt;
    cur = mk(1, 2, 1, 0, 0, 0, 0, 0);
    wr_reg(cur);
    nxt = mk(3, 5, 2, 0, 0, 1, 0, 0);
    run_access(0, 20, 1, nxt, -1);
    chk("R9 old active width", width, 3);
    chk("R9 old done index", didx, 8);
    cur = nxt;
    run_access(0, 0, -1, 0, -1);
    chk("R9 new setup gap", gap, 5);
    chk("R9 new active width", width, 6);
    chk("R9 new done index", didx, 14);
  endtask

  task automatic t_collide;
    cur = mk(2, 3, 1, 1, 1, 1, 0, 0);
    wr_reg(cur);
    run_access(0, 1000, 256, cur | 32'h1000, -1);
    chk("R10 collision width", width, 257);
    chk("R10 set wins over clear", reg_rdata[12], 1'b1);
    chk("R10 irq after collision", irq, 1'b1);
    wr_reg(cur | 32'h1000);
    @(negedge clk);
    chk("R6 clear after collision", reg_rdata[12], 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; start = 1'b0;
    is_write = 1'b0; ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regmap;
    t_phases;
    t_busy;
    t_mon_off;
    t_stretch;
    t_restart;
    t_wdog;
    t_suspend;
    t_midwrite;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule